// File: doc/BRIEF.md
# Atomic Memory Swap Sequencer

This block executes one indivisible exchange between a register and a memory location. It accepts a decoded swap command with these parts: a condition-pass flag, a byte/word select, a destination register index, a source value and an address. It then runs a locked read of the location and a locked write of the source value to that same location. An internal cycle follows, and the block then hands the loaded value back for write-back into the destination register.

The memory bus may reject either cycle through an abort input. An abort on the read, on the write, or on both yields exactly one trap request, raised together with the completion pulse. In that case the register write-back is withheld, so software can re-run the same command once the fault is resolved. A command whose condition failed completes at once, with no bus traffic and no write-back.

Top module: `swp_seq`

## Requirements
- R1: For an executed command, the read cycle (bus_req_o=1, bus_we_o=0) comes first and the write cycle (bus_req_o=1, bus_we_o=1) follows it to the same bus_addr_o. bus_lock_o is high in both cycles.
- R2: If a command is accepted at clock edge k, the read is presented in the cycle after k, the write in the next cycle, and an internal cycle with no request and no lock in the cycle after that. done_o is high in the fourth cycle after k.
- R3: In word mode (byte_i=0), the full 32-bit source value is driven on bus_wdata_o. The full 32-bit read word is returned on rf_wdata_o with rf_we_o=1 and rf_idx_o equal to the command's index.
- R4: In byte mode (byte_i=1), bus_byte_o is 1 during both cycles. bus_wdata_o carries source bits 7:0 repeated in every 8-bit lane, and only the addressed byte of memory changes.
- R5: In byte mode, rf_wdata_o is the byte at lane addr[1:0] of the read word, with lane 0 at bits 7:0 (little-endian), zero-extended to 32 bits.
- R6: When cond_pass_i=0 at acceptance, no bus request occurs. done_o pulses in the cycle after acceptance, with rf_we_o=0 and abort_trap_o=0.
- R7: An abort on the read cycle skips the write. done_o and abort_trap_o are high in the next cycle, rf_we_o stays 0, and memory is unchanged.
- R8: An abort on the write cycle gives done_o with abort_trap_o=1 and rf_we_o=0 at the normal completion time. abort_trap_o is high only in the done_o cycle.
- R9: Every operand is captured at acceptance. Changes on src_val_i, addr_i or the other command inputs after acceptance do not affect the cycles in flight, so an old register value reaches memory even when destination and source are the same register.
- R10: busy_o is high from the cycle after acceptance through the done_o cycle. done_o lasts one cycle. cmd_valid_i is ignored while busy_o is high.
- R11: While rst_ni is low, busy_o, done_o, abort_trap_o, bus_req_o, bus_lock_o and rf_we_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Swap command present (taken when idle) |
| cond_pass_i | input | 1 | Condition evaluated true |
| byte_i | input | 1 | 1: byte swap, 0: word swap |
| rd_idx_i | input | 4 | Destination register index |
| src_val_i | input | 32 | Source register value |
| addr_i | input | 32 | Memory address |
| busy_o | output | 1 | Sequencer occupied |
| done_o | output | 1 | One-cycle completion pulse |
| abort_trap_o | output | 1 | Data-abort trap request, with done_o |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1: write cycle, 0: read cycle |
| bus_lock_o | output | 1 | Bus held locked |
| bus_byte_o | output | 1 | Byte-sized transfer |
| bus_addr_o | output | 32 | Bus address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, valid in the read cycle |
| bus_abort_i | input | 1 | Bus rejects the current cycle |
| rf_we_o | output | 1 | Register write-back enable |
| rf_idx_o | output | 4 | Register write-back index |
| rf_wdata_o | output | 32 | Register write-back data |

## Verification
Each command is driven for one cycle and then walked one cycle at a time, sampling at the falling edge. The read is checked one cycle after the accepting edge and the write two cycles after. The idle internal cycle is checked three cycles after, and done_o with the write-back or trap four cycles after. For a failed condition done_o is checked after one cycle, and for a read abort after two. Memory contents are compared with the bench's model once completion has been seen. After acceptance the command inputs are driven to different values, and a stray command is raised during the read cycle, so that any use of live inputs appears in those same sampled cycles.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_INT  = 3'd3,
    ST_DONE = 3'd4
  } swp_state_e;
endpackage

// File: rtl/swp_ctl.sv
module swp_ctl
  import swp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cond_pass_i,
  input  logic bus_abort_i,
  output logic accept_o,
  output logic load_en_o,
  output logic busy_o,
  output logic done_o,
  output logic trap_o,
  output logic bus_req_o,
  output logic bus_we_o,
  output logic bus_lock_o,
  output logic rf_we_o
);
  swp_state_e state_q, state_d;
  logic abort_q, abort_d;
  logic exec_q, exec_d;

  always_comb begin
    state_d = state_q;
    abort_d = abort_q;
    exec_d  = exec_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) begin
        exec_d  = cond_pass_i;
        abort_d = 1'b0;
        state_d = cond_pass_i ? ST_RD : ST_DONE;
      end
      ST_RD: begin
        // read abort: skip the write so memory stays intact
        if (bus_abort_i) begin
          abort_d = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (bus_abort_i) abort_d = 1'b1;
        state_d = ST_INT;
      end
      ST_INT:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      exec_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      exec_q  <= exec_d;
    end
  end

  assign accept_o   = (state_q == ST_IDLE) && cmd_valid_i;
  assign load_en_o  = (state_q == ST_RD) && !bus_abort_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign trap_o     = done_o && abort_q;
  assign bus_req_o  = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we_o   = (state_q == ST_WR);
  assign bus_lock_o = bus_req_o;
  assign rf_we_o    = done_o && exec_q && !abort_q;
endmodule

// File: rtl/swp_lane.sv
module swp_lane #(
  parameter int unsigned DW = 32,
  localparam int unsigned NLANE = DW / 8,
  localparam int unsigned LSW = $clog2(NLANE)
) (
  input  logic           byte_i,
  input  logic [LSW-1:0] lane_i,
  input  logic [DW-1:0]  src_i,
  input  logic [DW-1:0]  rdata_i,
  output logic [DW-1:0]  store_o,
  output logic [DW-1:0]  load_o
);
  logic [DW-1:0] rep;
  logic [DW-1:0] shifted;

  for (genvar g = 0; g < NLANE; g++) begin : g_rep
    assign rep[g*8 +: 8] = src_i[7:0];
  end

  assign shifted = rdata_i >> {lane_i, 3'b000};
  assign store_o = byte_i ? rep : src_i;
  assign load_o  = byte_i ? {{(DW-8){1'b0}}, shifted[7:0]} : rdata_i;
endmodule

// File: rtl/swp_oper.sv
module swp_oper #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          load_en_i,
  input  logic          byte_i,
  input  logic [RW-1:0] idx_i,
  input  logic [DW-1:0] src_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] load_i,
  output logic          byte_o,
  output logic [RW-1:0] idx_o,
  output logic [DW-1:0] src_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= 1'b0;
      idx_o  <= '0;
      src_o  <= '0;
      addr_o <= '0;
      load_o <= '0;
    end else begin
      if (accept_i) begin
        byte_o <= byte_i;
        idx_o  <= idx_i;
        src_o  <= src_i;
        addr_o <= addr_i;
      end
      if (load_en_i) load_o <= load_i;
    end
  end
endmodule

// File: rtl/swp_seq.sv
module swp_seq #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4,
  localparam int unsigned LSW = $clog2(DW / 8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cond_pass_i,
  input  logic          byte_i,
  input  logic [RW-1:0] rd_idx_i,
  input  logic [DW-1:0] src_val_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_trap_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_lock_o,
  output logic          bus_byte_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_abort_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_idx_o,
  output logic [DW-1:0] rf_wdata_o
);
  logic          accept, load_en;
  logic          op_byte;
  logic [DW-1:0] op_src, lane_store, lane_load;
  logic [AW-1:0] op_addr;

  swp_ctl i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cond_pass_i (cond_pass_i),
    .bus_abort_i (bus_abort_i),
    .accept_o    (accept),
    .load_en_o   (load_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .trap_o      (abort_trap_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_lock_o  (bus_lock_o),
    .rf_we_o     (rf_we_o)
  );

  swp_oper #(.DW(DW), .AW(AW), .RW(RW)) i_oper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .load_en_i (load_en),
    .byte_i    (byte_i),
    .idx_i     (rd_idx_i),
    .src_i     (src_val_i),
    .addr_i    (addr_i),
    .load_i    (lane_load),
    .byte_o    (op_byte),
    .idx_o     (rf_idx_o),
    .src_o     (op_src),
    .addr_o    (op_addr),
    .load_o    (rf_wdata_o)
  );

  swp_lane #(.DW(DW)) i_lane (
    .byte_i  (op_byte),
    .lane_i  (op_addr[LSW-1:0]),
    .src_i   (op_src),
    .rdata_i (bus_rdata_i),
    .store_o (lane_store),
    .load_o  (lane_load)
  );

  assign bus_addr_o  = op_addr;
  assign bus_byte_o  = op_byte && bus_req_o;
  assign bus_wdata_o = lane_store;
endmodule

// File: rtl/swp_seq_chk.sv
module swp_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cond_pass_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          abort_trap_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_lock_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_abort_i,
  input logic          rf_we_o
);
  AST_LOCK_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_lock_o); // R1
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && !bus_abort_i |=> bus_req_o && bus_we_o); // R1
  AST_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> $past(bus_req_o && !bus_we_o) && $stable(bus_addr_o)); // R1
  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |=> !bus_lock_o && busy_o && !done_o); // R2
  AST_NOP_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i && !cond_pass_i |=> done_o && !bus_req_o && !rf_we_o); // R6
  AST_READ_ABORT_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_abort_i |=> done_o && abort_trap_o && !bus_req_o); // R7
  AST_TRAP_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_trap_o |-> done_o && !rf_we_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o && !done_o && !rf_we_o); // R10
endmodule

bind swp_seq swp_seq_chk #(.AW(AW)) i_swp_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cond_pass_i  (cond_pass_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .abort_trap_o (abort_trap_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_lock_o   (bus_lock_o),
  .bus_addr_o   (bus_addr_o),
  .bus_abort_i  (bus_abort_i),
  .rf_we_o      (rf_we_o)
);

// File: tb/test_swp_seq.sv
`timescale 1ns/1ps
module test_swp_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cond_pass = 1'b0, byte_sel = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] src_val = '0, addr = '0;
  logic        busy, done, trap, req, we, lock, bbyte, rf_we;
  logic [31:0] baddr, wdata, rdata, rf_wdata;
  logic [3:0]  rf_idx;
  logic        abort, inj_rab = 1'b0, inj_wab = 1'b0;
  logic [31:0] mem [16];
  int unsigned errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  swp_seq i_swp_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cond_pass_i(cond_pass),
    .byte_i(byte_sel), .rd_idx_i(rd_idx), .src_val_i(src_val), .addr_i(addr),
    .busy_o(busy), .done_o(done), .abort_trap_o(trap), .bus_req_o(req),
    .bus_we_o(we), .bus_lock_o(lock), .bus_byte_o(bbyte), .bus_addr_o(baddr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_abort_i(abort),
    .rf_we_o(rf_we), .rf_idx_o(rf_idx), .rf_wdata_o(rf_wdata)
  );

  assign rdata = mem[baddr[5:2]];
  assign abort = req && (we ? inj_wab : inj_rab);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1111_1111 * i + 32'h0A0B_0C0D;
    end else if (req && we && !abort) begin
      if (bbyte) mem[baddr[5:2]][baddr[1:0]*8 +: 8] <= wdata[baddr[1:0]*8 +: 8];
      else       mem[baddr[5:2]] <= wdata;
    end
  end

  function automatic logic [31:0] exp_load(logic [31:0] w, bit b, logic [31:0] a);
    return b ? {24'h0, w[a[1:0]*8 +: 8]} : w;
  endfunction

  function automatic logic [31:0] exp_merge(logic [31:0] w, logic [31:0] s, bit b, logic [31:0] a);
    logic [31:0] r = w;
    if (b) r[a[1:0]*8 +: 8] = s[7:0];
    else   r = s;
    return r;
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic run_op(bit c, bit b, logic [3:0] idx, logic [31:0] s, logic [31:0] a,
                        bit rab, bit wab, bit poke);
    logic [31:0] old, wexp;
    @(negedge clk);
    cmd_valid = 1'b1; cond_pass = c; byte_sel = b; rd_idx = idx; src_val = s; addr = a;
    inj_rab = rab; inj_wab = wab;
    old = mem[a[5:2]];
    @(negedge clk);
    // R9: scramble inputs after acceptance
    cmd_valid = 1'b0; cond_pass = ~c; byte_sel = ~b; rd_idx = ~idx; src_val = ~s; addr = a ^ 32'h24;
    if (!c) begin
      chk("R6 done", {31'b0, done}, 1);
      chk("R6 req", {31'b0, req}, 0);
      chk("R6 rf_we", {31'b0, rf_we}, 0);
      chk("R6 trap", {31'b0, trap}, 0);
      @(negedge clk);
      chk("R10 idle after nop", {30'b0, busy, done}, 0);
      chk("R6 mem", mem[a[5:2]], old);
      return;
    end
    chk("R2 read cycle", {29'b0, req, we, lock}, 3'b101);
    chk("R1 read addr", baddr, a);
    chk("R10 busy", {31'b0, busy}, 1);
    chk("R4 byte flag rd", {31'b0, bbyte}, {31'b0, b});
    if (poke) begin cmd_valid = 1'b1; cond_pass = 1'b0; end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rab) begin
      chk("R7 done+trap", {29'b0, done, trap, req}, 3'b110);
      chk("R7 rf_we", {31'b0, rf_we}, 0);
      chk("R7 mem", mem[a[5:2]], old);
      @(negedge clk);
      chk("R10 idle after abort", {29'b0, busy, done, trap}, 0);
      return;
    end
    chk("R2 write cycle", {29'b0, req, we, lock}, 3'b111);
    chk("R1 write addr", baddr, a);
    wexp = b ? {4{s[7:0]}} : s;
    chk(b ? "R4 wdata" : "R3 R9 wdata", wdata, wexp);
    @(negedge clk);
    chk("R2 internal", {28'b0, req, lock, busy, done}, 4'b0010);
    @(negedge clk);
    chk("R2 done", {31'b0, done}, 1);
    chk("R8 trap", {31'b0, trap}, {31'b0, wab});
    chk("R8 rf_we", {31'b0, rf_we}, {31'b0, !wab});
    if (!wab) begin
      chk("R3 rf_idx", {28'b0, rf_idx}, {28'b0, idx});
      chk(b ? "R5 load byte" : "R3 load word", rf_wdata, exp_load(old, b, a));
      chk(b ? "R4 mem byte" : "R3 mem word", mem[a[5:2]], exp_merge(old, s, b, a));
    end else begin
      chk("R8 mem", mem[a[5:2]], old);
    end
    @(negedge clk);
    chk("R10 done pulse", {29'b0, busy, done, trap}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #12;
    chk("R11 reset", {26'b0, busy, done, trap, req, lock, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {28'b0, busy, done, req, rf_we}, 0);
    run_op(1, 0, 4'd3, 32'hDEAD_BEEF, 32'h10, 0, 0, 0);  // R3 word
    run_op(1, 0, 4'd3, 32'h1234_5678, 32'h10, 0, 0, 0);  // R3 returns prior store
    for (int l = 0; l < 4; l++)
      run_op(1, 1, 4'd5, 32'hFFFF_FF00 | (32'h40 + l), 32'h20 + l, 0, 0, 0); // R4 R5 lanes
    run_op(0, 0, 4'd1, 32'h5555_5555, 32'h08, 0, 0, 0);  // R6
    run_op(1, 0, 4'd2, 32'hAAAA_0000, 32'h0C, 1, 0, 0);  // R7
    run_op(1, 1, 4'd2, 32'h0000_00AA, 32'h0D, 0, 1, 0);  // R8
    run_op(1, 0, 4'd2, 32'hCAFE_0001, 32'h0C, 1, 1, 0);  // R7 both abort
    run_op(1, 0, 4'd7, 32'h0F0F_0F0F, 32'h18, 0, 0, 1);  // R10 stray command
    for (int n = 0; n < 300; n++) begin
      bit c  = ($urandom % 8) != 0;
      bit b  = $urandom[0];
      bit ra = ($urandom % 8) == 0;
      bit wa = ($urandom % 8) == 0;
      logic [31:0] a = {26'b0, 6'($urandom)};
      if (!b) a[1:0] = 2'b00;
      run_op(c, b, 4'($urandom), $urandom, a, ra, wa, ($urandom % 4) == 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule